// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the control core of an in-order pipeline with five stages, in this order: fetch, decode, ALU, memory and writeback. Once per cycle it is offered a descriptor for the next instruction: its PC, its class, two source register numbers, a destination register number, and hit/miss flags from the instruction cache and the data cache. It moves the descriptors through its stage registers. It freezes the pipe for cache-miss penalties, inserts a bubble when the static branch guess was wrong, and tells the datapath where each decode-stage operand comes from. The datapath, the register file and the caches are outside the block.

The descriptor source holds its descriptor until `accept_o` is high. `stall_o` marks a frozen cycle. During a frozen cycle no stage advances, nothing is accepted and nothing retires. A branch counts as taken when the PC of the next accepted instruction differs from the branch PC plus 4. `pred_taken_i` selects the static guess: 1 means taken, 0 means not taken. Two free-running counters report elapsed cycles and retired instructions.

Top module: `pl_hazard_ctrl`

## Requirements
- R1: Without stalls, an instruction accepted in cycle k shows `retire_o`=1 with `retire_pc_o` equal to its PC in cycle k+5. Instructions retire in acceptance order, and `accept_o` is only high when `in_valid_i` is high.
- R2: A descriptor presented with `in_imiss_i`=1 holds `stall_o` high for 10 cycles, starting in the cycle it is first presented. It is accepted in the 11th cycle.
- R3: A load (class 1) with `in_dmiss_i`=1, accepted in cycle k, raises `stall_o` in cycle k+4, when it sits in the memory stage. The stall lasts 10 cycles and the load retires in cycle k+15.
- R4: A store (class 2) with `in_dmiss_i`=1, accepted in cycle k, raises `stall_o` in cycle k+5, when it sits in writeback. The stall lasts 10 cycles and the store retires in cycle k+15.
- R5: Penalties that become due in the same cycle run one after another and each lasts a full 10 cycles. The order is: store miss in writeback, then load miss in memory, then instruction miss at fetch.
- R6: For the instruction in decode, `fwd_a_o` (first source) and `fwd_b_o` (second source) read 2'b01 when the ALU-stage instruction writes that register, and 2'b10 when only the memory-stage instruction writes it. When both write it, the ALU stage wins. Classes 0 (ALU) and 1 (load) write their destination.
- R7: A select reads 2'b00 in three cases: the source register is 0; the only matching producer is in writeback; or the matching instruction is a store (class 2) or a branch (class 3).
- R8: If the instruction accepted before a new descriptor is a branch (class 3) and its taken/not-taken outcome differs from `pred_taken_i`, the block raises `bubble_o` for one cycle. In that cycle it does not accept, and it accepts in the next cycle. A correct guess, or a jump after a non-branch, costs no bubble.
- R9: `cycle_cnt_o` counts every clock edge after reset. `instr_cnt_o` counts retired instructions only, never bubbles. Both are 0 in reset.
- R10: While `stall_o` is high, `accept_o` and `retire_o` stay low and the decode-stage PC does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_taken_i | input | 1 | Static guess: 1 taken, 0 not taken |
| in_valid_i | input | 1 | Descriptor offered |
| in_pc_i | input | 32 | Instruction PC |
| in_cls_i | input | 2 | Class: 0 ALU, 1 load, 2 store, 3 branch |
| in_rs1_i | input | 5 | First source register |
| in_rs2_i | input | 5 | Second source register |
| in_rd_i | input | 5 | Destination register |
| in_imiss_i | input | 1 | Instruction cache missed |
| in_dmiss_i | input | 1 | Data cache missed (load/store) |
| accept_o | output | 1 | Descriptor taken this cycle |
| stall_o | output | 1 | Pipe frozen this cycle |
| bubble_o | output | 1 | Misprediction bubble inserted this cycle |
| fwd_a_o | output | 2 | First-source select: 0 regfile, 1 ALU, 2 memory |
| fwd_b_o | output | 2 | Second-source select, same encoding |
| dec_valid_o | output | 1 | Decode stage holds an instruction |
| dec_pc_o | output | 32 | Decode-stage PC |
| retire_o | output | 1 | Writeback instruction retires this cycle |
| retire_pc_o | output | 32 | PC of retiring instruction |
| cycle_cnt_o | output | 32 | Cycle counter |
| instr_cnt_o | output | 32 | Retired-instruction counter |

## Verification
Two miss penalties can become due in the same cycle. In one case a missing store reaches writeback just as a missing load behind it reaches memory. In the other, an instruction-miss descriptor arrives at fetch in the very cycle that an earlier load miss reaches memory; idle cycles are timed so that it lands there. In both cases the bench requires one unbroken stall run of 20 cycles. For the second case it also requires the fetch descriptor to be accepted exactly 20 cycles after it was first offered. A scoreboard follows every instruction through decode and retire, including the forwarding selects around misprediction bubbles.

// File: rtl/pl_hazard_pkg.sv
package pl_hazard_pkg;
  localparam int PC_W    = 32;
  localparam int RID_W   = 5;
  localparam int N_SRC   = 2;
  localparam int N_STAGE = 5;
  localparam int ST_FET  = 0;
  localparam int ST_DEC  = 1;
  localparam int ST_ALU  = 2;
  localparam int ST_MEM  = 3;
  localparam int ST_WB   = 4;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_BRANCH = 2'd3
  } op_cls_e;

  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_ALU  = 2'd1,
    FWD_MEM  = 2'd2
  } fwd_sel_e;

  typedef struct packed {
    logic             vld;
    logic [PC_W-1:0]  pc;
    op_cls_e          cls;
    logic [RID_W-1:0] rs1;
    logic [RID_W-1:0] rs2;
    logic [RID_W-1:0] rd;
    logic             dmiss;
  } slot_t;

  function automatic logic slot_writes(slot_t s);
    return s.vld && (s.cls == CLS_ALU || s.cls == CLS_LOAD) && (s.rd != '0);
  endfunction
endpackage

// File: rtl/pl_miss_seq.sv
module pl_miss_seq #(
  parameter int PENALTY = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_wb_i,
  input  logic ev_mem_i,
  input  logic ev_fetch_i,
  output logic freeze_o,
  output logic clr_wb_o,
  output logic clr_mem_o,
  output logic grant_fetch_o
);
  localparam int CW = $clog2(PENALTY + 1);

  logic [CW-1:0] cnt_q;
  logic          idle, start;

  assign idle          = (cnt_q == '0);
  // fixed order: writeback, then memory, then fetch
  assign clr_wb_o      = idle & ev_wb_i;
  assign clr_mem_o     = idle & ~ev_wb_i & ev_mem_i;
  assign grant_fetch_o = idle & ~ev_wb_i & ~ev_mem_i & ev_fetch_i;
  assign start         = clr_wb_o | clr_mem_o | grant_fetch_o;
  assign freeze_o      = ~idle | start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (start) cnt_q <= CW'(PENALTY - 1);
    else if (!idle) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pl_fetch_gate.sv
module pl_fetch_gate
  import pl_hazard_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pred_taken_i,
  input  logic            in_valid_i,
  input  logic [PC_W-1:0] in_pc_i,
  input  logic            in_is_br_i,
  input  logic            in_imiss_i,
  input  logic            freeze_i,
  input  logic            grant_i,
  output logic            imiss_req_o,
  output logic            accept_o,
  output logic            bubble_o
);
  logic [PC_W-1:0] last_pc_q;
  logic            last_br_q, bub_done_q, served_q;
  logic            taken, mispred;

  assign taken       = (in_pc_i != last_pc_q + PC_W'(4));
  assign mispred     = in_valid_i & last_br_q & ~bub_done_q & (taken != pred_taken_i);
  assign imiss_req_o = in_valid_i & in_imiss_i & ~served_q;
  assign bubble_o    = ~freeze_i & ~imiss_req_o & mispred;
  assign accept_o    = in_valid_i & ~freeze_i & ~imiss_req_o & ~mispred;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pc_q  <= '0;
      last_br_q  <= 1'b0;
      bub_done_q <= 1'b0;
      served_q   <= 1'b0;
    end else begin
      if (grant_i)  served_q   <= 1'b1;
      if (bubble_o) bub_done_q <= 1'b1;
      if (accept_o) begin
        last_pc_q  <= in_pc_i;
        last_br_q  <= in_is_br_i;
        bub_done_q <= 1'b0;
        served_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pl_fwd_sel.sv
module pl_fwd_sel
  import pl_hazard_pkg::*;
(
  input  logic             use_i,
  input  logic [RID_W-1:0] src_i,
  input  logic             alu_wr_i,
  input  logic [RID_W-1:0] alu_rd_i,
  input  logic             mem_wr_i,
  input  logic [RID_W-1:0] mem_rd_i,
  output fwd_sel_e         sel_o
);
  always_comb begin
    sel_o = FWD_NONE;
    if (use_i && src_i != '0) begin
      if (alu_wr_i && alu_rd_i == src_i)      sel_o = FWD_ALU;
      else if (mem_wr_i && mem_rd_i == src_i) sel_o = FWD_MEM;
    end
  end
endmodule

// File: rtl/pl_counters.sv
module pl_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  output logic [CNT_W-1:0] cycle_cnt_o,
  output logic [CNT_W-1:0] instr_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_cnt_o <= '0;
      instr_cnt_o <= '0;
    end else begin
      cycle_cnt_o <= cycle_cnt_o + 1'b1;
      if (retire_i) instr_cnt_o <= instr_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pl_hazard_ctrl.sv
module pl_hazard_ctrl
  import pl_hazard_pkg::*;
#(
  parameter int MISS_PENALTY = 10,
  parameter int CNT_W        = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pred_taken_i,
  input  logic             in_valid_i,
  input  logic [PC_W-1:0]  in_pc_i,
  input  logic [1:0]       in_cls_i,
  input  logic [RID_W-1:0] in_rs1_i,
  input  logic [RID_W-1:0] in_rs2_i,
  input  logic [RID_W-1:0] in_rd_i,
  input  logic             in_imiss_i,
  input  logic             in_dmiss_i,
  output logic             accept_o,
  output logic             stall_o,
  output logic             bubble_o,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             dec_valid_o,
  output logic [PC_W-1:0]  dec_pc_o,
  output logic             retire_o,
  output logic [PC_W-1:0]  retire_pc_o,
  output logic [CNT_W-1:0] cycle_cnt_o,
  output logic [CNT_W-1:0] instr_cnt_o
);
  slot_t            pipe_q [N_STAGE];
  slot_t            in_slot;
  logic             freeze, clr_wb, clr_mem, grant_f, imiss_req;
  logic             ev_wb, ev_mem;
  logic [RID_W-1:0] src_w [N_SRC];
  fwd_sel_e         sel_w [N_SRC];

  always_comb begin
    in_slot.vld   = 1'b1;
    in_slot.pc    = in_pc_i;
    in_slot.cls   = op_cls_e'(in_cls_i);
    in_slot.rs1   = in_rs1_i;
    in_slot.rs2   = in_rs2_i;
    in_slot.rd    = in_rd_i;
    in_slot.dmiss = in_dmiss_i;
  end

  assign ev_wb  = pipe_q[ST_WB].vld  && pipe_q[ST_WB].cls  == CLS_STORE && pipe_q[ST_WB].dmiss;
  assign ev_mem = pipe_q[ST_MEM].vld && pipe_q[ST_MEM].cls == CLS_LOAD  && pipe_q[ST_MEM].dmiss;

  pl_miss_seq #(.PENALTY(MISS_PENALTY)) u_miss (
    .clk_i, .rst_ni,
    .ev_wb_i      (ev_wb),
    .ev_mem_i     (ev_mem),
    .ev_fetch_i   (imiss_req),
    .freeze_o     (freeze),
    .clr_wb_o     (clr_wb),
    .clr_mem_o    (clr_mem),
    .grant_fetch_o(grant_f)
  );

  pl_fetch_gate u_fetch (
    .clk_i, .rst_ni,
    .pred_taken_i,
    .in_valid_i,
    .in_pc_i,
    .in_is_br_i (in_cls_i == 2'(CLS_BRANCH)),
    .in_imiss_i,
    .freeze_i   (freeze),
    .grant_i    (grant_f),
    .imiss_req_o(imiss_req),
    .accept_o,
    .bubble_o
  );

  // stage registers: shift when not frozen; a served miss flag is cleared in place
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_STAGE; s++) pipe_q[s] <= '0;
    end else if (!freeze) begin
      pipe_q[ST_FET] <= accept_o ? in_slot : '0;
      for (int s = 1; s < N_STAGE; s++) pipe_q[s] <= pipe_q[s-1];
    end else begin
      if (clr_wb)  pipe_q[ST_WB].dmiss  <= 1'b0;
      if (clr_mem) pipe_q[ST_MEM].dmiss <= 1'b0;
    end
  end

  assign src_w[0] = pipe_q[ST_DEC].rs1;
  assign src_w[1] = pipe_q[ST_DEC].rs2;

  for (genvar g = 0; g < N_SRC; g++) begin : g_fwd
    pl_fwd_sel u_sel (
      .use_i   (pipe_q[ST_DEC].vld),
      .src_i   (src_w[g]),
      .alu_wr_i(slot_writes(pipe_q[ST_ALU])),
      .alu_rd_i(pipe_q[ST_ALU].rd),
      .mem_wr_i(slot_writes(pipe_q[ST_MEM])),
      .mem_rd_i(pipe_q[ST_MEM].rd),
      .sel_o   (sel_w[g])
    );
  end

  assign fwd_a_o     = 2'(sel_w[0]);
  assign fwd_b_o     = 2'(sel_w[1]);
  assign stall_o     = freeze;
  assign dec_valid_o = pipe_q[ST_DEC].vld;
  assign dec_pc_o    = pipe_q[ST_DEC].pc;
  assign retire_o    = pipe_q[ST_WB].vld & ~freeze;
  assign retire_pc_o = pipe_q[ST_WB].pc;

  pl_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .retire_i   (retire_o),
    .cycle_cnt_o,
    .instr_cnt_o
  );
endmodule

// File: rtl/pl_hazard_ctrl_chk.sv
module pl_hazard_ctrl_chk #(
  parameter int MISS_PENALTY = 10,
  parameter int CNT_W        = 32,
  parameter int PC_W         = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             accept_o,
  input logic             stall_o,
  input logic             bubble_o,
  input logic             retire_o,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic [PC_W-1:0]  dec_pc_o,
  input logic [CNT_W-1:0] cycle_cnt_o,
  input logic [CNT_W-1:0] instr_cnt_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (stall_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  assert_accept_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> in_valid_i);
  assert_freeze_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!accept_o && !retire_o));
  assert_dec_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(dec_pc_o));
  assert_fwd_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11));
  assert_bubble_alone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (!accept_o && !stall_o));
  assert_instr_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> instr_cnt_o == $past(instr_cnt_o) + CNT_W'($past(retire_o)));
  assert_cycle_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cycle_cnt_o == $past(cycle_cnt_o) + 1'b1);
  assert_run_whole_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && run_q != '0) |-> (int'(run_q) % MISS_PENALTY == 0));
endmodule

bind pl_hazard_ctrl pl_hazard_ctrl_chk #(
  .MISS_PENALTY(MISS_PENALTY), .CNT_W(CNT_W), .PC_W(pl_hazard_pkg::PC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .accept_o(accept_o),
  .stall_o(stall_o), .bubble_o(bubble_o), .retire_o(retire_o), .fwd_a_o(fwd_a_o),
  .fwd_b_o(fwd_b_o), .dec_pc_o(dec_pc_o), .cycle_cnt_o(cycle_cnt_o),
  .instr_cnt_o(instr_cnt_o)
);

// File: tb/pl_hazard_ctrl_tb_top.sv
`timescale 1ns/1ps
module pl_hazard_ctrl_tb_top;
  localparam int PEN = 10;

  logic        clk = 0, rst_n = 0, pred_taken = 0, in_valid = 0;
  logic [31:0] in_pc = 0;
  logic [1:0]  in_cls = 0;
  logic [4:0]  in_rs1 = 0, in_rs2 = 0, in_rd = 0;
  logic        in_imiss = 0, in_dmiss = 0;
  logic        accept_o, stall_o, bubble_o, dec_valid_o, retire_o;
  logic [1:0]  fwd_a_o, fwd_b_o;
  logic [31:0] dec_pc_o, retire_pc_o, cycle_cnt_o, instr_cnt_o;

  always #10 clk = ~clk;

  pl_hazard_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pred_taken_i(pred_taken), .in_valid_i(in_valid),
    .in_pc_i(in_pc), .in_cls_i(in_cls), .in_rs1_i(in_rs1), .in_rs2_i(in_rs2),
    .in_rd_i(in_rd), .in_imiss_i(in_imiss), .in_dmiss_i(in_dmiss),
    .accept_o(accept_o), .stall_o(stall_o), .bubble_o(bubble_o),
    .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o), .dec_valid_o(dec_valid_o),
    .dec_pc_o(dec_pc_o), .retire_o(retire_o), .retire_pc_o(retire_pc_o),
    .cycle_cnt_o(cycle_cnt_o), .instr_cnt_o(instr_cnt_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int stall_seen = 0, bub_seen = 0, retired = 0, frz_viol = 0;
  int exp_stalls = 0, exp_bubs = 0, sent = 0;
  int rise_cyc = 0, run = 0, last_run = 0;
  bit prev_stall = 0, done = 0;

  logic [31:0] dq_pc[$], rq_pc[$];
  logic [1:0]  dq_fa[$], dq_fb[$];
  int          rq_cyc[$];

  // bench model of the two slots ahead of the next decode
  bit h1_wr = 0, h2_wr = 0;
  logic [4:0] h1_rd = 0, h2_rd = 0;
  logic [31:0] b_last_pc = 0;
  bit b_last_br = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fsel(input logic [4:0] src);
    if (src == 0) return 2'd0;
    if (h1_wr && h1_rd == src) return 2'd1;
    if (h2_wr && h2_rd == src) return 2'd2;
    return 2'd0;
  endfunction

  task automatic push_slot(input bit wr, input logic [4:0] rd);
    h2_wr = h1_wr; h2_rd = h1_rd;
    h1_wr = wr && rd != 0; h1_rd = rd;
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 0;
      @(negedge clk);
      if (!stall_o) push_slot(0, 0);
      @(posedge clk); #1;
    end
  endtask

  task automatic send(input logic [31:0] pc, input logic [1:0] cls, input logic [4:0] rs1,
                      input logic [4:0] rs2, input logic [4:0] rd, input bit imiss,
                      input bit dmiss, input bit iso, output int pres, output int acc);
    bit taken;
    taken = (pc != b_last_pc + 32'd4);
    if (b_last_br && (taken != pred_taken)) begin
      exp_bubs++;
      push_slot(0, 0);
    end
    dq_pc.push_back(pc); dq_fa.push_back(fsel(rs1)); dq_fb.push_back(fsel(rs2));
    push_slot(cls == 2'd0 || cls == 2'd1, rd);
    if (imiss) exp_stalls += PEN;
    if (dmiss && (cls == 2'd1 || cls == 2'd2)) exp_stalls += PEN;
    in_valid = 1; in_pc = pc; in_cls = cls; in_rs1 = rs1; in_rs2 = rs2; in_rd = rd;
    in_imiss = imiss; in_dmiss = dmiss;
    @(negedge clk);
    pres = cyc;
    while (!accept_o) @(negedge clk);
    acc = cyc;
    rq_pc.push_back(pc);
    rq_cyc.push_back(iso ? acc + 5 + ((dmiss && cls != 2'd0) ? PEN : 0) : -1);
    b_last_pc = pc; b_last_br = (cls == 2'd3); sent++;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // monitor: pops decode and retire expectations
  always @(negedge clk) if (rst_n) begin
    if (stall_o) begin
      stall_seen++;
      if (!prev_stall) rise_cyc = cyc;
      run++;
      if (accept_o || retire_o) frz_viol++;
    end else begin
      if (prev_stall) last_run = run;
      run = 0;
    end
    prev_stall = stall_o;
    if (bubble_o) bub_seen++;
    if (dec_valid_o && !stall_o) begin
      if (dq_pc.size() == 0) chk(0, "R6 decode unexpected", dec_pc_o, 0);
      else begin
        logic [31:0] p; logic [1:0] a, b;
        p = dq_pc.pop_front(); a = dq_fa.pop_front(); b = dq_fb.pop_front();
        chk(dec_pc_o == p, "R1 decode order", dec_pc_o, p);
        chk(fwd_a_o == a, "R6 R7 fwd_a", fwd_a_o, a);
        chk(fwd_b_o == b, "R6 R7 fwd_b", fwd_b_o, b);
      end
    end
    if (retire_o) begin
      retired++;
      if (rq_pc.size() == 0) chk(0, "R1 retire unexpected", retire_pc_o, 0);
      else begin
        logic [31:0] p; int c;
        p = rq_pc.pop_front(); c = rq_cyc.pop_front();
        chk(retire_pc_o == p, "R1 retire order", retire_pc_o, p);
        if (c >= 0) chk(cyc == c, "R1 R3 R4 retire cycle", cyc, c);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int p, k, p2, k2;
    repeat (3) @(negedge clk);
    chk(cycle_cnt_o == 0 && instr_cnt_o == 0, "R9 reset counters", cycle_cnt_o, 0);
    chk(!stall_o && !retire_o && !dec_valid_o && !bubble_o, "R10 reset outputs", stall_o, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R1: latency and order
    send(32'h1000, 0, 0, 0, 1, 0, 0, 1, p, k);
    idle(8);
    for (int i = 0; i < 5; i++) send(32'h1004 + 4*i, 0, 0, 0, 5'(2 + i), 0, 0, 0, p, k);
    idle(8);

    // R6: forwarding from ALU and MEM, ALU priority
    send(32'h1100, 0, 0, 0, 5, 0, 0, 0, p, k);
    send(32'h1104, 1, 0, 0, 6, 0, 0, 0, p, k);
    send(32'h1108, 0, 6, 5, 7, 0, 0, 0, p, k);
    send(32'h110c, 0, 0, 0, 9, 0, 0, 0, p, k);
    send(32'h1110, 0, 0, 0, 9, 0, 0, 0, p, k);
    send(32'h1114, 2, 9, 9, 0, 0, 0, 0, p, k);
    idle(8);

    // R7: writeback producer, register 0, store/branch producers
    send(32'h1200, 0, 0, 0, 8, 0, 0, 0, p, k);
    send(32'h1204, 0, 0, 0, 3, 0, 0, 0, p, k);
    send(32'h1208, 0, 0, 0, 4, 0, 0, 0, p, k);
    send(32'h120c, 0, 8, 0, 0, 0, 0, 0, p, k);
    send(32'h1210, 2, 0, 0, 11, 0, 0, 0, p, k);
    send(32'h1214, 0, 11, 0, 0, 0, 0, 0, p, k);
    send(32'h1218, 0, 0, 0, 0, 0, 0, 0, p, k);
    send(32'h121c, 0, 0, 0, 12, 0, 0, 0, p, k);
    idle(8);

    // R8: not-taken guess, then taken guess
    send(32'h2000, 0, 0, 0, 13, 0, 0, 0, p, k);
    send(32'h2004, 3, 13, 0, 0, 0, 0, 0, p, k);
    send(32'h2400, 0, 13, 0, 14, 0, 0, 0, p, k);
    send(32'h2404, 3, 14, 0, 0, 0, 0, 0, p, k);
    send(32'h2408, 0, 14, 0, 0, 0, 0, 0, p, k);
    idle(8);
    chk(bub_seen == exp_bubs && exp_bubs == 1, "R8 not-taken bubbles", bub_seen, 1);
    pred_taken = 1;
    send(32'h3000, 3, 0, 0, 0, 0, 0, 0, p, k);
    send(32'h3004, 0, 0, 0, 15, 0, 0, 0, p, k);
    send(32'h3008, 3, 15, 0, 0, 0, 0, 0, p, k);
    send(32'h5000, 0, 0, 0, 0, 0, 0, 0, p, k);
    send(32'h9000, 0, 0, 0, 0, 0, 0, 0, p, k);
    idle(8);
    chk(bub_seen == exp_bubs && exp_bubs == 2, "R8 taken bubbles", bub_seen, 2);
    pred_taken = 0;

    // R2: instruction miss
    send(32'h6000, 0, 0, 0, 1, 1, 0, 1, p, k);
    chk(k - p == PEN, "R2 imiss accept delay", k - p, PEN);
    chk(rise_cyc == p, "R2 stall start", rise_cyc, p);
    idle(10);
    chk(last_run == PEN, "R2 stall length", last_run, PEN);

    // R3: load miss in memory stage
    send(32'h6100, 1, 0, 0, 2, 0, 1, 1, p, k);
    idle(25);
    chk(rise_cyc == k + 4, "R3 load stall start", rise_cyc, k + 4);
    chk(last_run == PEN, "R3 load stall length", last_run, PEN);

    // R4: store miss in writeback
    send(32'h6200, 2, 0, 0, 0, 0, 1, 1, p, k);
    idle(25);
    chk(rise_cyc == k + 5, "R4 store stall start", rise_cyc, k + 5);
    chk(last_run == PEN, "R4 store stall length", last_run, PEN);

    // R5: store miss in WB and load miss in MEM in one cycle
    send(32'h7000, 2, 0, 0, 0, 0, 1, 0, p, k);
    send(32'h7004, 1, 0, 0, 3, 0, 1, 0, p, k2);
    idle(40);
    chk(rise_cyc == k + 5, "R5 joint stall start", rise_cyc, k + 5);
    chk(last_run == 2 * PEN, "R5 wb+mem run", last_run, 2 * PEN);

    // R5: load miss in MEM and fetch miss in one cycle
    send(32'h7100, 1, 0, 0, 4, 0, 1, 0, p, k);
    idle(3);
    send(32'h7104, 0, 0, 0, 5, 1, 0, 0, p2, k2);
    chk(p2 == k + 4, "R5 fetch miss timing", p2, k + 4);
    chk(k2 - p2 == 2 * PEN, "R5 mem+fetch accept delay", k2 - p2, 2 * PEN);
    idle(20);
    chk(last_run == 2 * PEN, "R5 mem+fetch run", last_run, 2 * PEN);

    // R9, R10: totals
    chk(stall_seen == exp_stalls, "R2 R3 R4 total stalls", stall_seen, exp_stalls);
    chk(bub_seen == exp_bubs, "R8 total bubbles", bub_seen, exp_bubs);
    chk(instr_cnt_o == sent && retired == sent, "R9 instr count", instr_cnt_o, sent);
    chk(cycle_cnt_o == cyc, "R9 cycle count", cycle_cnt_o, cyc);
    chk(frz_viol == 0, "R10 activity during stall", frz_viol, 0);
    chk(dq_pc.size() == 0 && rq_pc.size() == 0, "R1 scoreboard drained", rq_pc.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule